// File: doc/BRIEF.md
# Configuration-Change Error Interrupt Unit

This block guards the configuration of an audio converter interface. It keeps a snapshot of the serial format, the speed mode and the master/slave selection. When a register write changes any of them while the device is powered up, it raises a serial-port error. It also follows the measured master-clock-to-sample-rate ratio. In slave mode, a ratio change while powered up raises the serial-port error and the clocking error in the same cycle. In master mode, a ratio change raises nothing. A write of a key value to the test register raises a test-mode error. Four converter overflow strobes and an external clock-fault strobe are also collected.

Every event sets a sticky bit in an 8-bit status register, whatever its mask. Reading the status register over the register bus clears it. A mask register holds one bit per source, and a 1 in that bit stops the source from driving the interrupt. The interrupt output is active high and registered. It is the OR of all status bits that are not masked, as they stood one cycle earlier.

Top module: `cfg_err_irq`

## Requirements
- R1: On a cycle with `wr_en` high and `pwr_dn` low, a `ser_fmt` value that differs from the value held at the previous write sets status bit 6 (serial-port error).
- R2: Under the same write conditions, a changed `spd_mode` or a changed `is_master` also sets status bit 6.
- R3: A write taken while `pwr_dn` is high updates the held snapshot without setting any error. A later powered-up write with the same field values then sets nothing.
- R4: With `is_master` low (slave), a change of `mclk_ratio` from one cycle to the next while `pwr_dn` is low sets status bits 6 and 5 together.
- R5: With `is_master` high, or with `pwr_dn` high, a ratio change sets no status bit.
- R6: A write of `TEST_KEY` (default 8'hA5) to `TEST_ADDR` (default 8'h12) sets status bit 7 (test-mode error). Any other data written to that address sets nothing.
- R7: `ovf_strb[k]` high for one cycle sets status bit k (bit 0 is channel 1, bit 3 is channel 4).
- R8: Status bits are sticky and independent of the mask. A read with `rd_en` high at `STAT_ADDR` (default 8'h11) returns the status on `rd_data` in the next cycle and clears the status. An event in the same cycle as the clearing read leaves its bit set.
- R9: `irq` equals the OR of (status AND NOT mask) one cycle earlier. A mask bit of 1 keeps its source off `irq`.
- R10: Bit 4 of the mask register (`MASK_ADDR`, default 8'h10) ignores writes and reads as 0. Status bit 4 is always 0.
- R11: After reset the status is 0, the mask is 8'hEF (all sources blocked), `irq` is 0 and `rd_data` is 0.
- R12: `clk_fault` high sets status bit 5 (clocking error) in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe; the configuration fields are compared on this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data (0 when no read) |
| pwr_dn | input | 1 | Global power-down indication |
| ser_fmt | input | FMT_W | Serial format field after the write |
| spd_mode | input | SPD_W | Speed mode field after the write |
| is_master | input | 1 | 1 = master, 0 = slave |
| mclk_ratio | input | RATIO_W | Measured master-clock-to-sample-rate ratio |
| ovf_strb | input | 4 | Per-channel overflow strobes |
| clk_fault | input | 1 | External clocking fault strobe |
| status | output | 8 | Sticky status bits |
| irq | output | 1 | Registered interrupt, active high |

## Verification
Two functions can act on the same status bit in the same cycle: setting a bit from a new event, and clearing the register through a status read. The bench provokes this on purpose: it reads the status while an overflow strobe is high, and the random phase repeats such overlaps many times. The expected result is that the read returns the bits held before that cycle and the new bit survives the clear. A second overlap comes from a slave-mode ratio change that falls on a powered-up field-changing write, where both sources must merge into one set of bits 6 and 5.

// File: rtl/cei_pkg.sv
package cei_pkg;
  localparam int ST_W   = 8;
  localparam int B_TM   = 7;
  localparam int B_SP   = 6;
  localparam int B_CK   = 5;
  localparam int B_RSV  = 4;
  localparam int N_OVF  = 4;

  // Assemble the per-cycle event vector in status bit order.
  function automatic logic [ST_W-1:0] pack_ev(input logic tm, input logic sp,
                                              input logic ck,
                                              input logic [N_OVF-1:0] ovf);
    return {tm, sp, ck, 1'b0, ovf};
  endfunction

  // Bits that are allowed to reach the interrupt.
  function automatic logic irq_term(input logic [ST_W-1:0] st,
                                    input logic [ST_W-1:0] mk);
    return |(st & ~mk);
  endfunction

  // Strip the reserved position from a written mask.
  function automatic logic [ST_W-1:0] clean_rsv(input logic [ST_W-1:0] d);
    logic [ST_W-1:0] keep;
    keep = ~(ST_W'(1) << B_RSV);
    return d & keep;
  endfunction
endpackage

// File: rtl/cei_watch.sv
module cei_watch #(
  parameter int FMT_W   = 2,
  parameter int SPD_W   = 2,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               pwr_dn,
  input  logic [FMT_W-1:0]   fmt,
  input  logic [SPD_W-1:0]   spd,
  input  logic               master,
  input  logic [RATIO_W-1:0] ratio,
  output logic               cfg_chg,
  output logic               ratio_chg
);
  logic [FMT_W-1:0]   s_fmt;
  logic [SPD_W-1:0]   s_spd;
  logic               s_ms;
  logic [RATIO_W-1:0] p_ratio;
  logic               r_vld;
  logic               diff;

  always_comb begin
    diff      = (fmt != s_fmt) || (spd != s_spd) || (master != s_ms);
    cfg_chg   = wr_en && !pwr_dn && diff;
    ratio_chg = r_vld && (ratio != p_ratio) && !pwr_dn && !master;
  end

  // Snapshot of the fields, refreshed only by a register write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_fmt <= '0;
      s_spd <= '0;
      s_ms  <= 1'b0;
    end else if (wr_en) begin
      s_fmt <= fmt;
      s_spd <= spd;
      s_ms  <= master;
    end
  end

  // The ratio is a measurement and is followed every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ratio <= '0;
      r_vld   <= 1'b0;
    end else begin
      p_ratio <= ratio;
      r_vld   <= 1'b1;
    end
  end
endmodule

// File: rtl/cei_sticky.sv
module cei_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] st
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // Set takes priority over clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st[i] <= 1'b0;
      else if (clr) st[i] <= set[i];
      else          st[i] <= st[i] | set[i];
    end
  end
endmodule

// File: rtl/cfg_err_irq.sv
module cfg_err_irq
  import cei_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               FMT_W     = 2,
  parameter int               SPD_W     = 2,
  parameter int               RATIO_W   = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 8'h12,
  parameter logic [7:0]        TEST_KEY  = 8'hA5,
  parameter logic [7:0]        MASK_RST  = 8'hEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  input  logic               pwr_dn,
  input  logic [FMT_W-1:0]   ser_fmt,
  input  logic [SPD_W-1:0]   spd_mode,
  input  logic               is_master,
  input  logic [RATIO_W-1:0] mclk_ratio,
  input  logic [3:0]         ovf_strb,
  input  logic               clk_fault,
  output logic [7:0]         status,
  output logic               irq
);
  logic            cfg_chg, ratio_chg;
  logic            sp_ev, ck_ev, tm_ev;
  logic [ST_W-1:0] ev;
  logic [ST_W-1:0] mask_q;
  logic            stat_rd;

  cei_watch #(.FMT_W(FMT_W), .SPD_W(SPD_W), .RATIO_W(RATIO_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pwr_dn(pwr_dn),
    .fmt(ser_fmt), .spd(spd_mode), .master(is_master), .ratio(mclk_ratio),
    .cfg_chg(cfg_chg), .ratio_chg(ratio_chg)
  );

  always_comb begin
    sp_ev   = cfg_chg | ratio_chg;
    ck_ev   = ratio_chg | clk_fault;
    tm_ev   = wr_en && (wr_addr == TEST_ADDR) && (wr_data == TEST_KEY);
    ev      = pack_ev(tm_ev, sp_ev, ck_ev, ovf_strb);
    stat_rd = rd_en && (rd_addr == STAT_ADDR);
  end

  cei_sticky #(.W(ST_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(ev), .clr(stat_rd), .st(status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            mask_q <= MASK_RST;
    else if (wr_en && wr_addr == MASK_ADDR) mask_q <= clean_rsv(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= irq_term(status, mask_q);
      if (stat_rd)                             rd_data <= status;
      else if (rd_en && rd_addr == MASK_ADDR)  rd_data <= mask_q;
      else                                     rd_data <= '0;
    end
  end
endmodule

// File: rtl/cfg_err_irq_chk.sv
module cfg_err_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic [7:0] mask_q,
  input logic       stat_rd,
  input logic       sp_ev,
  input logic       tm_ev,
  input logic       wr_en,
  input logic       pwr_dn,
  input logic       is_master,
  input logic [3:0] ovf_strb,
  input logic [7:0] rd_data,
  input logic       irq
);
  assert_pd_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !sp_ev);

  assert_master_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !wr_en) |-> !sp_ev);

  assert_tm_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tm_ev |=> status[7]);

  assert_ovf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_strb[0] |=> status[0]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status)));

  assert_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (rd_data == $past(status)));

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask_q[7:5]) && (&mask_q[3:0])) |=> !irq);

  assert_rsv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !status[4] && !mask_q[4]);
endmodule

bind cfg_err_irq cfg_err_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .mask_q(mask_q),
  .stat_rd(stat_rd), .sp_ev(sp_ev), .tm_ev(tm_ev), .wr_en(wr_en),
  .pwr_dn(pwr_dn), .is_master(is_master), .ovf_strb(ovf_strb),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_cfg_err_irq.sv
module sim_cfg_err_irq;
  localparam logic [7:0] MASK_A = 8'h10;
  localparam logic [7:0] STAT_A = 8'h11;
  localparam logic [7:0] TEST_A = 8'h12;
  localparam logic [7:0] KEY    = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, pwr_dn = 1'b0, is_master = 1'b0;
  logic       clk_fault = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [1:0] ser_fmt = '0, spd_mode = '0;
  logic [3:0] mclk_ratio = '0, ovf_strb = '0;
  logic [7:0] rd_data, status;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference state
  logic [7:0] m_stat = '0, m_mask = 8'hEF, m_rd = '0;
  logic       m_irq = 1'b0;
  logic [1:0] s_fmt = '0, s_spd = '0;
  logic       s_ms = 1'b0, m_rvld = 1'b0;
  logic [3:0] m_pr = '0;

  always #4 clk = ~clk;

  cfg_err_irq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwr_dn(pwr_dn), .ser_fmt(ser_fmt), .spd_mode(spd_mode),
    .is_master(is_master), .mclk_ratio(mclk_ratio), .ovf_strb(ovf_strb),
    .clk_fault(clk_fault), .status(status), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                     input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_events(input logic [7:0] old_stat);
    logic cfgc, rc, tm;
    cfgc = wr_en && !pwr_dn &&
           (ser_fmt != s_fmt || spd_mode != s_spd || is_master != s_ms);
    rc   = m_rvld && (mclk_ratio != m_pr) && !pwr_dn && !is_master;
    tm   = wr_en && wr_addr == TEST_A && wr_data == KEY;
    return {tm, cfgc | rc, rc | clk_fault, 1'b0, ovf_strb} | (old_stat & 8'h00);
  endfunction

  // One clock: predict, advance, compare, then drop the strobes.
  task automatic tick(input string tag);
    logic [7:0] ev;
    ev    = ref_events(m_stat);
    m_irq = |(m_stat & ~m_mask);
    if (rd_en && rd_addr == STAT_A)      m_rd = m_stat;
    else if (rd_en && rd_addr == MASK_A) m_rd = m_mask;
    else                                 m_rd = 8'h00;
    m_stat = ((rd_en && rd_addr == STAT_A) ? 8'h00 : m_stat) | ev;
    if (wr_en && wr_addr == MASK_A) m_mask = wr_data & 8'hEF;
    if (wr_en) begin
      s_fmt = ser_fmt; s_spd = spd_mode; s_ms = is_master;
    end
    m_pr = mclk_ratio; m_rvld = 1'b1;
    @(posedge clk); #2;
    chk({7'd0, irq}, {7'd0, m_irq}, {tag, " irq (R9)"});
    chk(rd_data, m_rd, {tag, " rd_data (R8)"});
    chk(status, m_stat, {tag, " status"});
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; ovf_strb = '0; clk_fault = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick(tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1'b1; rd_addr = a; tick(tag);
    chk(rd_data, exp, tag);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #2;
    chk({7'd0, irq}, 8'h00, "R11 irq in reset");
    chk(rd_data, 8'h00, "R11 rd_data in reset");
    chk(status, 8'h00, "R11 status in reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(STAT_A, 8'h00, "R11 status after reset");
    rd(MASK_A, 8'hEF, "R11 mask after reset");
    // Reserved mask bit
    wr(MASK_A, 8'hFF, "R10 write all ones");
    rd(MASK_A, 8'hEF, "R10 bit 4 reads 0");
    wr(MASK_A, 8'h10, "R10 write only bit 4");
    rd(MASK_A, 8'h00, "R10 bit 4 ignored");
    // Field changes while powered up
    ser_fmt = 2'd1; wr(8'h00, 8'h00, "R1 format change");
    rd(STAT_A, 8'h40, "R1 serial-port error");
    pwr_dn = 1'b1; ser_fmt = 2'd2; wr(8'h00, 8'h00, "R3 change in power-down");
    rd(STAT_A, 8'h00, "R3 no error in power-down");
    pwr_dn = 1'b0; wr(8'h00, 8'h00, "R3 same values");
    rd(STAT_A, 8'h00, "R3 snapshot was updated");
    spd_mode = 2'd3; wr(8'h00, 8'h00, "R2 speed change");
    rd(STAT_A, 8'h40, "R2 speed error");
    is_master = 1'b1; wr(8'h00, 8'h00, "R2 master/slave change");
    rd(STAT_A, 8'h40, "R2 master/slave error");
    // Ratio changes
    mclk_ratio = 4'd5; tick("R5 master ratio change");
    rd(STAT_A, 8'h00, "R5 master ratio silent");
    pwr_dn = 1'b1; is_master = 1'b0; wr(8'h00, 8'h00, "R3 back to slave");
    mclk_ratio = 4'd6; tick("R5 ratio change in power-down");
    rd(STAT_A, 8'h00, "R5 power-down ratio silent");
    pwr_dn = 1'b0; mclk_ratio = 4'd9; tick("R4 slave ratio change");
    rd(STAT_A, 8'h60, "R4 both errors");
    // Test-mode key
    wr(TEST_A, KEY, "R6 key write");
    rd(STAT_A, 8'h80, "R6 test-mode error");
    wr(TEST_A, 8'h5A, "R6 other data");
    rd(STAT_A, 8'h00, "R6 no error");
    // Overflow and clock fault
    ovf_strb = 4'b0100; tick("R7 overflow ch3");
    rd(STAT_A, 8'h04, "R7 overflow bit 2");
    clk_fault = 1'b1; tick("R12 clock fault");
    rd(STAT_A, 8'h20, "R12 clocking error");
    // Set and clear in one cycle
    ovf_strb = 4'b0010; tick("R8 first event");
    ovf_strb = 4'b0001; rd(STAT_A, 8'h02, "R8 read during event");
    rd(STAT_A, 8'h01, "R8 event survived clear");
    // Mask gating and latency
    wr(MASK_A, 8'hEF, "R9 mask all");
    ovf_strb = 4'b0100; tick("R9 masked event");
    tick("R9 masked idle");
    chk({7'd0, irq}, 8'h00, "R9 masked irq low");
    wr(MASK_A, 8'h00, "R9 unmask");
    chk({7'd0, irq}, 8'h00, "R9 irq one cycle behind mask");
    tick("R9 after unmask");
    chk({7'd0, irq}, 8'h01, "R9 irq raised");
    rd(STAT_A, 8'h04, "R8 sticky under mask");
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      pwr_dn   = (r[2:0] == 3'd0);
      if (r[7:4] == 4'd0) ser_fmt = 2'($urandom);
      if (r[11:8] == 4'd0) spd_mode = 2'($urandom);
      if (r[15:12] == 4'd0) is_master = ~is_master;
      if (r[18:16] == 3'd0) mclk_ratio = 4'($urandom);
      clk_fault = (r[23:19] == 5'd0);
      ovf_strb = {($urandom % 10) == 0, ($urandom % 10) == 0,
                  ($urandom % 10) == 0, ($urandom % 10) == 0};
      wr_en = (r[25:24] == 2'd0);
      case (r[27:26])
        2'd0: begin wr_addr = MASK_A; wr_data = 8'($urandom); end
        2'd1: begin wr_addr = TEST_A; wr_data = r[28] ? KEY : 8'($urandom); end
        default: begin wr_addr = 8'($urandom); wr_data = 8'($urandom); end
      endcase
      rd_en = (r[30:29] == 2'd0);
      rd_addr = r[31] ? STAT_A : (r[0] ? MASK_A : 8'h33);
      tick("R1 R2 R4 R7 R8 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule